// File: doc/BRIEF.md
# Bit-Serial Timekeeper

This unit keeps a time-of-day clock (hours, minutes, seconds), a stopwatch-style timer (minutes, seconds, tenths) and an alarm setting (hours, minutes), all as BCD digits. Every digit lives in one 64-bit circulating shift register. The register rotates one bit per clock, least significant bit first. A single one-bit incrementer with a carry flip-flop rewrites each bit as it passes the head. One full rotation of 64 clocks is a pass, and one pass is one tenth of a second. The input clock is therefore 640 Hz, and no prescaler is needed.

A decade digit inside the ring counts passes modulo ten, and its carry drives the seconds. The timer gets its increment only while it is running. The alarm never counts on its own: only the advance button changes it. Button presses are held pending and applied during the next pass. Digit values are copied to parallel output latches at each pass boundary. These latches feed external segment decoders. The alarm flag is latched at the same point.

Top module: `tk_watch`

## Requirements
- R1: While reset is held, every output digit is 0 and `alarm_on` is 0.
- R2: `tod_bcd` packs {hours tens, hours units, minutes tens, minutes units, seconds tens, seconds units}, 4 bits per digit, with the most significant digit first. Seconds advance once every ten passes of 64 clocks. Seconds and minutes roll from 59 to 00 and carry into the next field. 23:59:59 rolls to 00:00:00.
- R3: `tmr_bcd` packs {minutes tens, minutes units, seconds tens, seconds units, tenths}. The timer advances by one tenth per pass while it runs and rolls from 59:59.9 to 00:00.0. `tmr_start` sets the running state and `tmr_stop` clears it, with stop winning when both are pressed. A press made during one pass acts in the next pass and appears on the outputs at the end of that pass.
- R4: `tmr_clear` zeroes all timer digits in the next pass. This overrides counting in that pass, and the running state is left as it was.
- R5: `adv_btn` with `sel_alarm`=0 adds one to the time-of-day field picked by `sel_hours`: 1 selects hours (mod 24) and 0 selects minutes (mod 60). No carry passes into other fields. The seconds are cleared, and any second tick in that pass is dropped. The selects are captured together with the press.
- R6: `adv_btn` with `sel_alarm`=1 does the same to the alarm field, with no carry and no change to the time of day. `alm_bcd` packs {hours tens, hours units, minutes tens, minutes units}.
- R7: At each pass end, `alarm_on` becomes 1 exactly when the new time-of-day hours and minutes equal the alarm setting held before that pass.
- R8: All outputs change only on the clock edge that starts a pass. They hold for the other 63 clocks of each pass.
- R9: The three functions run at once. The time of day keeps counting while the timer runs, is cleared or is stopped, and while the alarm is being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 640 Hz clock, one bit of rotation per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_alarm | input | 1 | Advance target: 1 alarm, 0 time of day |
| sel_hours | input | 1 | Advance field: 1 hours, 0 minutes |
| adv_btn | input | 1 | One-cycle advance request |
| tmr_start | input | 1 | One-cycle timer start request |
| tmr_stop | input | 1 | One-cycle timer stop request |
| tmr_clear | input | 1 | One-cycle timer clear request |
| tod_bcd | output | 24 | Time-of-day digits |
| tmr_bcd | output | 20 | Timer digits |
| alm_bcd | output | 16 | Alarm setting digits |
| alarm_on | output | 1 | Time matches alarm |

## Verification
Every digit shares one ring and one incrementer. A single wrong bit or a misplaced carry therefore shows up at the next pass boundary as a digit out of its BCD range, a wrong rollover, or damage to a neighbouring function. A wrong wrap limit stays hidden until that digit reaches its limit. For the hours this means the bench must drive the clock through 23:59:59 into midnight. An error in the alarm compare tap shows on `alarm_on` within one pass of the time reaching the alarm minute. Each pass result is compared against a pass-level reference model, so any mismatch is caught within 64 clocks.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int DIG_W  = 4;
  localparam int NDIG   = 16;
  localparam int RING_W = DIG_W * NDIG;
  localparam int CNT_W  = $clog2(RING_W);
  localparam int BIT_W  = $clog2(DIG_W);
  localparam int DIG_IW = CNT_W - BIT_W;

  typedef logic [DIG_W-1:0]  digit_t;
  typedef logic [DIG_IW-1:0] didx_t;

  // ring order, head first; each group is least significant digit first
  localparam didx_t D_PH  = didx_t'(0);   // pass decade
  localparam didx_t D_CSU = didx_t'(1);
  localparam didx_t D_CST = didx_t'(2);
  localparam didx_t D_CMU = didx_t'(3);
  localparam didx_t D_CMT = didx_t'(4);
  localparam didx_t D_CHU = didx_t'(5);
  localparam didx_t D_CHT = didx_t'(6);
  localparam didx_t D_TTE = didx_t'(7);
  localparam didx_t D_TSU = didx_t'(8);
  localparam didx_t D_TST = didx_t'(9);
  localparam didx_t D_TMU = didx_t'(10);
  localparam didx_t D_TMT = didx_t'(11);
  localparam didx_t D_AMU = didx_t'(12);
  localparam didx_t D_AMT = didx_t'(13);
  localparam didx_t D_AHU = didx_t'(14);
  localparam didx_t D_AHT = didx_t'(15);

  localparam int TOD_LO = 1 * DIG_W;
  localparam int TOD_W  = 6 * DIG_W;
  localparam int TMR_LO = 7 * DIG_W;
  localparam int TMR_W  = 5 * DIG_W;
  localparam int ALM_LO = 12 * DIG_W;
  localparam int ALM_W  = 4 * DIG_W;
  // ring position of the rewritten clock-minutes bit while the alarm bit sits at the head
  localparam int PEEK   = RING_W - (12 - 3) * DIG_W;

  function automatic digit_t dig_limit(input didx_t i);
    case (i)
      D_CST, D_CMT, D_TST, D_TMT, D_AMT: dig_limit = digit_t'(5);
      D_CHT, D_AHT:                      dig_limit = digit_t'(2);
      default:                           dig_limit = digit_t'(9);
    endcase
  endfunction

  function automatic logic dig_is_hu(input didx_t i);
    dig_is_hu = (i == D_CHU) || (i == D_AHU);
  endfunction
endpackage

// File: rtl/tk_ring.sv
module tk_ring #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         in_bit,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nx;

  always_comb begin
    q_nx = q;
    if (shift_en) q_nx = {in_bit, q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nx;
  end
endmodule

// File: rtl/tk_bit_alu.sv
module tk_bit_alu
  import tk_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   digit_start,
  input  digit_t head_dig,
  input  digit_t tens_dig,
  input  digit_t limit,
  input  logic   hour_units,
  input  logic   cin,
  input  logic   force_zero,
  output logic   out_bit,
  output logic   dcarry
);
  logic carry_q, carry_nx, zero_q, zero_nx, dcar_nx;
  logic at_lim, zero_now, zero_eff, c_eff, sum;

  always_comb begin
    at_lim   = (head_dig == limit) ||
               (hour_units && head_dig == digit_t'(3) && tens_dig == digit_t'(2));
    zero_now = force_zero || (cin && at_lim);
    zero_eff = digit_start ? zero_now : zero_q;
    c_eff    = digit_start ? cin : carry_q;
    sum      = head_dig[0] ^ c_eff;
    carry_nx = head_dig[0] & c_eff;
    out_bit  = zero_eff ? 1'b0 : sum;
    zero_nx  = zero_eff;
    dcar_nx  = digit_start ? (cin && at_lim && !force_zero) : dcarry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
      dcarry  <= 1'b0;
    end else begin
      carry_q <= carry_nx;
      zero_q  <= zero_nx;
      dcarry  <= dcar_nx;
    end
  end
endmodule

// File: rtl/tk_seq.sv
module tk_seq
  import tk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_alarm,
  input  logic             sel_hours,
  input  logic             adv_btn,
  input  logic             tmr_start,
  input  logic             tmr_stop,
  input  logic             tmr_clear,
  input  logic             dcarry,
  output logic [CNT_W-1:0] cnt,
  output logic             cin,
  output logic             force_zero
);
  logic [CNT_W-1:0] cnt_nx;
  logic adv_p, alm_p, hrs_p, clr_p, adv_a, alm_a, hrs_a, clr_a, run, run_a;
  logic adv_p_nx, alm_p_nx, hrs_p_nx, clr_p_nx;
  logic adv_a_nx, alm_a_nx, hrs_a_nx, clr_a_nx, run_nx, run_a_nx;
  logic pass_start, adj_t, adj_a;
  didx_t dig;

  always_comb begin
    pass_start = (cnt == '0);
    dig        = cnt[CNT_W-1:BIT_W];
    cnt_nx     = (cnt == CNT_W'(RING_W - 1)) ? '0 : cnt + 1'b1;
    run_nx     = tmr_stop ? 1'b0 : (tmr_start ? 1'b1 : run);
    alm_p_nx   = adv_btn ? sel_alarm : alm_p;
    hrs_p_nx   = adv_btn ? sel_hours : hrs_p;
    if (pass_start) begin
      adv_a_nx = adv_p;  alm_a_nx = alm_p;  hrs_a_nx = hrs_p;
      clr_a_nx = clr_p;  run_a_nx = run;
      adv_p_nx = adv_btn;
      clr_p_nx = tmr_clear;
    end else begin
      adv_a_nx = adv_a;  alm_a_nx = alm_a;  hrs_a_nx = hrs_a;
      clr_a_nx = clr_a;  run_a_nx = run_a;
      adv_p_nx = adv_p | adv_btn;
      clr_p_nx = clr_p | tmr_clear;
    end
  end

  // carry source and clearing per digit slot
  always_comb begin
    adj_t      = adv_a & ~alm_a;
    adj_a      = adv_a & alm_a;
    cin        = dcarry;
    force_zero = 1'b0;
    case (dig)
      D_PH:         cin = 1'b1;
      D_CSU, D_CST: begin cin = adj_t ? 1'b0 : dcarry; force_zero = adj_t; end
      D_CMU:        cin = adj_t ? ~hrs_a : dcarry;
      D_CHU:        cin = adj_t ? hrs_a : dcarry;
      D_TTE:        begin cin = run_a; force_zero = clr_a; end
      D_TSU, D_TST, D_TMU, D_TMT: force_zero = clr_a;
      D_AMU:        cin = adj_a & ~hrs_a;
      D_AHU:        cin = adj_a & hrs_a;
      default:      cin = dcarry;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      adv_p <= 1'b0; alm_p <= 1'b0; hrs_p <= 1'b0; clr_p <= 1'b0;
      adv_a <= 1'b0; alm_a <= 1'b0; hrs_a <= 1'b0; clr_a <= 1'b0;
      run <= 1'b0;   run_a <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      adv_p <= adv_p_nx; alm_p <= alm_p_nx; hrs_p <= hrs_p_nx; clr_p <= clr_p_nx;
      adv_a <= adv_a_nx; alm_a <= alm_a_nx; hrs_a <= hrs_a_nx; clr_a <= clr_a_nx;
      run <= run_nx;     run_a <= run_a_nx;
    end
  end
endmodule

// File: rtl/tk_watch.sv
module tk_watch
  import tk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_alarm,
  input  logic             sel_hours,
  input  logic             adv_btn,
  input  logic             tmr_start,
  input  logic             tmr_stop,
  input  logic             tmr_clear,
  output logic [TOD_W-1:0] tod_bcd,
  output logic [TMR_W-1:0] tmr_bcd,
  output logic [ALM_W-1:0] alm_bcd,
  output logic             alarm_on
);
  logic [RING_W-1:0] ring;
  logic [CNT_W-1:0]  pass_cnt;
  logic new_bit, dcarry, cin, force_zero;
  logic pass_start, digit_start, in_win, mm, mm_nx;
  didx_t  dig;
  digit_t limit;
  logic   hour_units;

  tk_seq u_seq (
    .clk, .rst_n, .sel_alarm, .sel_hours, .adv_btn, .tmr_start, .tmr_stop,
    .tmr_clear, .dcarry, .cnt(pass_cnt), .cin, .force_zero
  );

  tk_ring #(.W(RING_W)) u_ring (
    .clk, .rst_n, .shift_en(1'b1), .in_bit(new_bit), .q(ring)
  );

  always_comb begin
    pass_start  = (pass_cnt == '0);
    digit_start = (pass_cnt[BIT_W-1:0] == '0);
    dig         = pass_cnt[CNT_W-1:BIT_W];
    limit       = dig_limit(dig);
    hour_units  = dig_is_hu(dig);
    in_win      = (dig >= D_AMU);
    mm_nx       = pass_start ? 1'b0 : (in_win ? (mm | (ring[0] ^ ring[PEEK])) : mm);
  end

  tk_bit_alu u_alu (
    .clk, .rst_n, .digit_start,
    .head_dig(ring[DIG_W-1:0]), .tens_dig(ring[2*DIG_W-1:DIG_W]),
    .limit, .hour_units, .cin, .force_zero, .out_bit(new_bit), .dcarry
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mm       <= 1'b0;
      tod_bcd  <= '0;
      tmr_bcd  <= '0;
      alm_bcd  <= '0;
      alarm_on <= 1'b0;
    end else begin
      mm <= mm_nx;
      if (pass_start) begin
        tod_bcd  <= ring[TOD_LO +: TOD_W];
        tmr_bcd  <= ring[TMR_LO +: TMR_W];
        alm_bcd  <= ring[ALM_LO +: ALM_W];
        alarm_on <= ~mm;
      end
    end
  end
endmodule

// File: rtl/tk_watch_chk.sv
module tk_watch_chk
  import tk_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [TOD_W-1:0] tod,
  input logic [TMR_W-1:0] tmr,
  input logic [ALM_W-1:0] alm,
  input logic             alarm_on
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         seen <= 1'b0;
    else if (cnt == '0) seen <= 1'b1;
  end

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> ($stable(tod) && $stable(tmr) && $stable(alm) && $stable(alarm_on)));

  assert_tod_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tod[3:0] <= 4'd9 && tod[7:4] <= 4'd5 && tod[11:8] <= 4'd9 && tod[15:12] <= 4'd5 &&
     tod[19:16] <= 4'd9 && (tod[23:20] < 4'd2 || (tod[23:20] == 4'd2 && tod[19:16] <= 4'd3))));

  assert_tmr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr[3:0] <= 4'd9 && tmr[7:4] <= 4'd9 && tmr[11:8] <= 4'd5 &&
     tmr[15:12] <= 4'd9 && tmr[19:16] <= 4'd5));

  assert_alm_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (alm[3:0] <= 4'd9 && alm[7:4] <= 4'd5 && alm[11:8] <= 4'd9 &&
     (alm[15:12] < 4'd2 || (alm[15:12] == 4'd2 && alm[11:8] <= 4'd3))));

  assert_flag_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && cnt == CNT_W'(1) && $stable(alm)) |-> (alarm_on == (tod[23:8] == alm)));
endmodule

bind tk_watch tk_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(pass_cnt), .tod(tod_bcd), .tmr(tmr_bcd),
  .alm(alm_bcd), .alarm_on(alarm_on)
);

// File: tb/tk_watch_test.sv
module tk_watch_test;
  import tk_pkg::*;

  logic clk = 1'b0;
  logic rst_n, sel_alarm, sel_hours, adv_btn, tmr_start, tmr_stop, tmr_clear;
  logic [TOD_W-1:0] tod_bcd;
  logic [TMR_W-1:0] tmr_bcd;
  logic [ALM_W-1:0] alm_bcd;
  logic alarm_on;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;
  int m_ph = 0, m_h = 0, m_m = 0, m_s = 0, m_tm = 0, m_ts = 0, m_tt = 0;
  int m_ah = 0, m_am = 0;
  bit m_flag = 0, m_runlvl = 0;
  bit p_adv = 0, p_alm = 0, p_hrs = 0, p_clr = 0, p_run = 0;

  always #2.5 clk = ~clk;

  tk_watch uut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<190000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  function automatic logic [23:0] tod_vec(int h, int m, int s);
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction
  function automatic logic [19:0] tmr_vec(int m, int s, int t);
    return {4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10), 4'(t)};
  endfunction
  function automatic logic [15:0] alm_vec(int h, int m);
    return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10)};
  endfunction

  // reference for one pass, using the requests captured for it
  task automatic model_pass();
    bit tick;
    int tt;
    tick = (m_ph == 9);
    m_ph = (m_ph + 1) % 10;
    if (p_adv && !p_alm) begin
      m_s = 0;
      if (p_hrs) m_h = (m_h + 1) % 24;
      else       m_m = (m_m + 1) % 60;
    end else if (tick) begin
      m_s++;
      if (m_s == 60) begin
        m_s = 0; m_m++;
        if (m_m == 60) begin m_m = 0; m_h = (m_h + 1) % 24; end
      end
    end
    if (p_clr) begin
      m_tm = 0; m_ts = 0; m_tt = 0;
    end else if (p_run) begin
      tt = ((m_tm * 60 + m_ts) * 10 + m_tt + 1) % 36000;
      m_tt = tt % 10; m_ts = (tt / 10) % 60; m_tm = tt / 600;
    end
    m_flag = (m_h == m_ah) && (m_m == m_am);
    if (p_adv && p_alm) begin
      if (p_hrs) m_ah = (m_ah + 1) % 24;
      else       m_am = (m_am + 1) % 60;
    end
  endtask

  task automatic check_all(input string tg);
    chk($sformatf("R2 time-of-day (%s)", tg), 32'(tod_bcd), 32'(tod_vec(m_h, m_m, m_s)));
    chk($sformatf("R3 timer (%s)", tg), 32'(tmr_bcd), 32'(tmr_vec(m_tm, m_ts, m_tt)));
    chk($sformatf("R6 alarm (%s)", tg), 32'(alm_bcd), 32'(alm_vec(m_ah, m_am)));
    chk($sformatf("R7 flag (%s)", tg), 32'(alarm_on), 32'(m_flag));
  endtask

  // one pass: starts just after a pass-start edge, ends just after the next one
  task automatic step(input bit adv, input bit alm, input bit hrs, input bit clr,
                      input bit st, input bit sp, input string tg);
    logic [60:0] snap;
    adv_btn = adv; sel_alarm = alm; sel_hours = hrs;
    tmr_clear = clr; tmr_start = st; tmr_stop = sp;
    @(negedge clk);
    adv_btn = 0; tmr_clear = 0; tmr_start = 0; tmr_stop = 0;
    snap = {tod_bcd, tmr_bcd, alm_bcd, alarm_on};
    repeat (62) @(negedge clk);
    chk($sformatf("R8 hold (%s)", tg), 32'({tod_bcd, tmr_bcd, alm_bcd, alarm_on} == snap), 32'd1);
    @(negedge clk);
    model_pass();
    p_adv = adv; p_alm = alm; p_hrs = hrs; p_clr = clr;
    if (sp) m_runlvl = 0; else if (st) m_runlvl = 1;
    p_run = m_runlvl;
    check_all(tg);
  endtask

  initial begin
    rst_n = 0; sel_alarm = 0; sel_hours = 0; adv_btn = 0;
    tmr_start = 0; tmr_stop = 0; tmr_clear = 0;
    void'($urandom(32'd7351));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset tod", 32'(tod_bcd), 32'd0);
    chk("R1 reset timer", 32'(tmr_bcd), 32'd0);
    chk("R1 reset alarm", 32'(alm_bcd), 32'd0);
    chk("R1 reset flag", 32'(alarm_on), 32'd0);
    rst_n = 1;
    @(negedge clk);
    m_flag = 1;
    check_all("R1 first boundary");

    for (int i = 0; i < 23; i++) step(1, 0, 1, 0, 0, 0, "R5 set hours");
    for (int i = 0; i < 59; i++) step(1, 0, 0, 0, 0, 0, "R5 set minutes");
    step(0, 0, 0, 0, 1, 0, "R3 start");
    for (int i = 0; i < 620; i++) step(0, 0, 0, 0, 0, 0, "R2 midnight run R9");
    step(0, 0, 0, 0, 0, 1, "R3 stop");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, "R3 held");
    step(0, 0, 0, 1, 0, 0, "R4 clear stopped");
    step(0, 0, 0, 0, 1, 1, "R3 start and stop");
    step(0, 0, 0, 1, 1, 0, "R4 clear with start");
    for (int i = 0; i < 15; i++) step(0, 0, 0, 0, 0, 0, "R3 count");
    step(0, 0, 0, 1, 0, 0, "R4 clear running");
    step(0, 0, 0, 0, 0, 0, "R4 after clear");
    for (int i = 0; i < 60; i++) step(1, 0, 0, 0, 0, 0, "R5 minute wrap");
    for (int i = 0; i < 61; i++) step(1, 1, 0, 0, 0, 0, "R6 alarm minute wrap R9");
    for (int i = 0; i < 25; i++) step(1, 1, 1, 0, 0, 0, "R6 alarm hour wrap");
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[1:0] == 2'd0, r[3], r[4], r[7:5] == 3'd0, r[10:8] == 3'd0,
           r[13:11] == 3'd0, "R9 mixed");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule